// File: doc/BRIEF.md
# Four-Channel Fly-By DMA Controller

This block moves words between a peripheral port and memory on behalf of up to four devices. Data never enters the controller: it only owns the bus, drives the address and fires a matched pair of strobes. One strobe makes the source put a word on the data lines. The other makes the destination take it in the same cycle.

Software sets up each channel through a small write port. Each channel has a start address, a transfer count and a direction bit. A device asks for service by raising its request line. The controller then raises a hold request to the processor and waits for hold acknowledge. It gives the winning device its acknowledge and then runs the whole block, one word per clock. After the last word it hands the bus back and pulses a completion interrupt.

Only one channel is active at a time. Pending requests are resolved by fixed priority when the bus is free.

Top module: `dma_fly_ctrl`

## Requirements
- R1: After reset, hold request, every device acknowledge, all four strobes and the completion interrupt are low, and every terminal-count flag is clear.
- R2: One clock after a live request is seen with the controller idle, hold request goes high. Neither a device acknowledge nor any strobe is driven while hold acknowledge is low.
- R3: The winning channel's acknowledge rises one clock before its first strobe cycle. It stays high through the last word, and at most one acknowledge is high at any time.
- R4: Direction bit 1 moves memory to the device: memory-read and I/O-write are asserted together. Direction bit 0 moves the device to memory: I/O-read and memory-write are asserted together. The two pairs are never active at once.
- R5: The first word uses the programmed address. The address steps up by one each word and wraps modulo 2^16. A programmed count of N yields exactly N+1 consecutive strobe cycles.
- R6: On the word where the count passes zero, the channel's terminal-count flag is set. A channel with this flag set ignores its request line until its count is written again.
- R7: When several live requests are pending, channel 0 wins and channel 3 loses. A block in progress is never preempted by a higher-priority request.
- R8: Hold request stays high from the grant until the last word. It falls in the clock after the last word, in the same cycle as a one-clock completion interrupt.
- R9: A register write selects the channel with `cfg_ch` and the field with `cfg_sel`: 0 loads the address, 1 loads the count and clears that channel's terminal-count flag, and 2 loads the direction from bit 0 of the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel written |
| cfg_sel | input | 2 | Field: 0 address, 1 count, 2 direction |
| cfg_wdata | input | 16 | Write data |
| dreq | input | 4 | Per-device service request |
| hlda | input | 1 | Hold acknowledge from the processor |
| hrq | output | 1 | Hold request to the processor |
| dack | output | 4 | Per-device acknowledge |
| addr | output | 16 | Memory address of the current word |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |
| tc_flag | output | 4 | Per-channel terminal-count flags |
| done_irq | output | 1 | One-clock completion pulse |

## Verification
A block in progress and a new request from a higher-priority channel can occur in the same cycle. To provoke this, channel 0 raises its request while channel 2 is already moving words. The scoreboard then requires every channel-2 word to appear before any channel-0 word, with addresses and strobe pairs taken from the programmed values. The bench also raises two requests together and keeps both lines high after service. This shows fixed priority and shows that a spent channel's still-raised request no longer reaches the bus.

// File: rtl/dma_fly_pkg.sv
package dma_fly_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HOLD,
      ST_ACK,
      ST_XFER,
      ST_DONE
   } seq_state_t;

   localparam logic [1:0] SEL_ADDR = 2'd0;
   localparam logic [1:0] SEL_CNT  = 2'd1;
   localparam logic [1:0] SEL_DIR  = 2'd2;
endpackage

// File: rtl/dma_fly_chan.sv
module dma_fly_chan
   import dma_fly_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_sel,
   input  logic [AW-1:0] wr_data,
   input  logic          step,
   output logic [AW-1:0] addr_o,
   output logic          last_o,
   output logic          dir_o,
   output logic          tc_o
);
   logic [AW-1:0] addr_q;
   logic [CW-1:0] cnt_q;
   logic          dir_q;
   logic          tc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
         dir_q  <= 1'b0;
         tc_q   <= 1'b0;
      end else if (step) begin
         addr_q <= addr_q + 1'b1;
         cnt_q  <= cnt_q - 1'b1;
         if (cnt_q == '0) tc_q <= 1'b1;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_ADDR: addr_q <= wr_data;
            SEL_CNT: begin
               cnt_q <= wr_data[CW-1:0];
               tc_q  <= 1'b0;
            end
            SEL_DIR:  dir_q <= wr_data[0];
            default:  ;
         endcase
      end
   end

   assign addr_o = addr_q;
   assign last_o = (cnt_q == '0);
   assign dir_o  = dir_q;
   assign tc_o   = tc_q;

   // R5: every word advances the address by one
   a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> addr_q == AW'($past(addr_q) + 1'b1));
   // R6: stepping past a zero count raises the flag
   a_r6_tc_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (step && last_o) |=> tc_q);
   // R9: a count write loads the value and clears the flag
   a_r9_count_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !step && wr_sel == SEL_CNT) |=> (cnt_q == $past(wr_data[CW-1:0]) && !tc_q));
endmodule

// File: rtl/dma_fly_arb.sv
module dma_fly_arb #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  req,
   output logic          gnt_valid,
   output logic [IW-1:0] gnt_idx
);
   always_comb begin
      gnt_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) gnt_idx = IW'(i);
      end
   end
   assign gnt_valid = |req;
endmodule

// File: rtl/dma_fly_seq.sv
module dma_fly_seq
   import dma_fly_pkg::*;
#(
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_any,
   input  logic [IW-1:0] win_idx,
   input  logic          hlda,
   input  logic          last,
   output logic          hrq,
   output logic          ack_act,
   output logic          xfer,
   output logic          done_irq,
   output logic [IW-1:0] act_idx
);
   seq_state_t state_q, state_d;
   logic [IW-1:0] idx_q;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (req_any) state_d = ST_HOLD;
         ST_HOLD: if (hlda) state_d = ST_ACK;
         ST_ACK:  state_d = ST_XFER;
         ST_XFER: if (last) state_d = ST_DONE;
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && req_any) idx_q <= win_idx;
      end
   end

   assign hrq      = (state_q == ST_HOLD) || (state_q == ST_ACK) || (state_q == ST_XFER);
   assign ack_act  = (state_q == ST_ACK) || (state_q == ST_XFER);
   assign xfer     = (state_q == ST_XFER);
   assign done_irq = (state_q == ST_DONE);
   assign act_idx  = idx_q;

   // R3: the acknowledge phase always precedes the first word
   a_r3_ack_before_word: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xfer) |-> $past(ack_act));
   // R8: the completion pulse lasts one clock
   a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |=> !done_irq);
endmodule

// File: rtl/dma_fly_ctrl.sv
module dma_fly_ctrl
   import dma_fly_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int AW     = 16,
   parameter int CW     = 16,
   localparam int IW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IW-1:0]     cfg_ch,
   input  logic [1:0]        cfg_sel,
   input  logic [AW-1:0]     cfg_wdata,
   input  logic [NUM_CH-1:0] dreq,
   input  logic              hlda,
   output logic              hrq,
   output logic [NUM_CH-1:0] dack,
   output logic [AW-1:0]     addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              io_rd,
   output logic              io_wr,
   output logic [NUM_CH-1:0] tc_flag,
   output logic              done_irq
);
   generate
      if (NUM_CH < 2) begin : g_bad_ch
         $error("NUM_CH must be at least 2");
      end
      if (CW > AW) begin : g_bad_cw
         $error("CW must not exceed AW");
      end
   endgenerate

   logic [AW-1:0]     ch_addr [NUM_CH];
   logic [NUM_CH-1:0] ch_last, ch_dir, req_live;
   logic              win_valid, ack_act, xfer;
   logic [IW-1:0]     win_idx, act_idx;

   genvar g;
   generate
      for (g = 0; g < NUM_CH; g++) begin : g_ch
         dma_fly_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_we && cfg_ch == IW'(g)),
            .wr_sel  (cfg_sel),
            .wr_data (cfg_wdata),
            .step    (xfer && act_idx == IW'(g)),
            .addr_o  (ch_addr[g]),
            .last_o  (ch_last[g]),
            .dir_o   (ch_dir[g]),
            .tc_o    (tc_flag[g])
         );
         assign dack[g] = ack_act && act_idx == IW'(g);
      end
   endgenerate

   assign req_live = dreq & ~tc_flag;

   dma_fly_arb #(.N(NUM_CH), .IW(IW)) u_arb (
      .req       (req_live),
      .gnt_valid (win_valid),
      .gnt_idx   (win_idx)
   );

   dma_fly_seq #(.IW(IW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_any  (win_valid),
      .win_idx  (win_idx),
      .hlda     (hlda),
      .last     (ch_last[act_idx]),
      .hrq      (hrq),
      .ack_act  (ack_act),
      .xfer     (xfer),
      .done_irq (done_irq),
      .act_idx  (act_idx)
   );

   assign addr   = ch_addr[act_idx];
   assign mem_rd = xfer &&  ch_dir[act_idx];
   assign io_wr  = xfer &&  ch_dir[act_idx];
   assign io_rd  = xfer && !ch_dir[act_idx];
   assign mem_wr = xfer && !ch_dir[act_idx];

   logic [NUM_CH-1:0] below_act;
   assign below_act = (NUM_CH'(1) << act_idx) - NUM_CH'(1);

   // R2: no acknowledge or strobe without an owned bus
   a_r2_bus_only_when_granted: assert property (@(posedge clk) disable iff (!rst_n)
      ((|dack) || mem_rd || mem_wr || io_rd || io_wr) |-> (hrq && hlda));
   // R4: strobes come in matched pairs only
   a_r4_strobe_pairs: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd == io_wr) && (io_rd == mem_wr) && !(mem_rd && io_rd));
   // R3: at most one device acknowledged
   a_r3_one_dack: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dack));
   // R7: the channel taken had no live lower-index rival
   a_r7_fixed_priority: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hrq) |-> (($past(req_live) & below_act) == '0));
   // R8: the bus is released only together with the completion pulse
   a_r8_release_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hrq) |-> done_irq);
endmodule

// File: tb/dma_fly_ctrl_tb.sv
module dma_fly_ctrl_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_ch = '0;
   logic [1:0]  cfg_sel = '0;
   logic [15:0] cfg_wdata = '0;
   logic [3:0]  dreq = '0;
   logic        hlda;
   logic        hrq, mem_rd, mem_wr, io_rd, io_wr, done_irq;
   logic [3:0]  dack, tc_flag;
   logic [15:0] addr;

   int n_checks = 0;
   int n_fail = 0;
   int irq_cnt = 0;
   logic [2:0] grant_pipe = '0;
   logic [18:0] exp_q[$];

   always #(CLK_PERIOD / 2) clk = ~clk;
   assign hlda = grant_pipe[2];

   dma_fly_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .dreq(dreq), .hlda(hlda),
      .hrq(hrq), .dack(dack), .addr(addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .io_rd(io_rd), .io_wr(io_wr), .tc_flag(tc_flag), .done_irq(done_irq)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic program_ch(input logic [1:0] ch, input logic [15:0] a,
                             input logic [15:0] c, input logic d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_ch = ch; cfg_sel = 2'd0; cfg_wdata = a;
      @(negedge clk);
      cfg_sel = 2'd1; cfg_wdata = c;
      @(negedge clk);
      cfg_sel = 2'd2; cfg_wdata = {15'd0, d};
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic push_block(input logic [1:0] ch, input logic [15:0] a,
                             input int c, input logic d);
      for (int i = 0; i <= c; i++) exp_q.push_back({ch, d, 16'(a + i)});
   endtask

   // processor model: grants two clocks after the request
   always @(negedge clk) grant_pipe <= {grant_pipe[1:0], hrq};

   // monitor: compare every strobe cycle with the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_rd || mem_wr || io_rd || io_wr) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R5", "unexpected word", {16'd0, addr}, 32'd0);
            end else begin
               logic [18:0] e;
               e = exp_q.pop_front();
               check(addr == e[15:0], "R5", "word address", addr, e[15:0]);
               check(dack == (4'd1 << e[18:17]), "R7", "acked channel", dack, 4'd1 << e[18:17]);
               check({mem_rd, io_wr, io_rd, mem_wr} == (e[16] ? 4'b1100 : 4'b0011),
                     "R4", "strobe pair", {mem_rd, io_wr, io_rd, mem_wr},
                     e[16] ? 4'b1100 : 4'b0011);
            end
         end
         if (done_irq) begin
            irq_cnt++;
            check(!hrq && dack == 0, "R8", "bus released with irq", {hrq, dack}, 0);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!hrq && dack == 0 && !done_irq, "R1", "reset outputs", {hrq, dack, done_irq}, 0);
      check({mem_rd, mem_wr, io_rd, io_wr} == 0, "R1", "reset strobes", {mem_rd, mem_wr, io_rd, io_wr}, 0);
      check(tc_flag == 0, "R1", "reset tc", tc_flag, 0);
      rst_n = 1'b1;

      program_ch(2'd2, 16'h1000, 16'd3, 1'b1);
      program_ch(2'd1, 16'h20FE, 16'd0, 1'b0);
      program_ch(2'd0, 16'hFFFE, 16'd2, 1'b0);
      program_ch(2'd3, 16'h4000, 16'd1, 1'b1);

      // single channel, memory to device, count 3 -> 4 words
      push_block(2'd2, 16'h1000, 3, 1'b1);
      dreq[2] = 1'b1;
      @(negedge clk);
      check(hrq == 1'b1, "R2", "hold request next clock", hrq, 1);
      check(dack == 0 && !hlda, "R2", "no ack before grant", dack, 0);
      while (dack == 0) @(negedge clk);
      check({mem_rd, mem_wr, io_rd, io_wr} == 0, "R3", "ack one clock before first word",
            {mem_rd, mem_wr, io_rd, io_wr}, 0);
      wait (irq_cnt == 1);
      @(negedge clk);
      check(exp_q.size() == 0, "R5", "count 3 gives 4 words", exp_q.size(), 0);
      check(tc_flag == 4'b0100, "R6", "tc after block", tc_flag, 4'b0100);

      // two requests together: channel 1 before channel 3
      push_block(2'd1, 16'h20FE, 0, 1'b0);
      push_block(2'd3, 16'h4000, 1, 1'b1);
      dreq[3] = 1'b1; dreq[1] = 1'b1;
      wait (irq_cnt == 3);
      @(negedge clk);
      check(exp_q.size() == 0, "R7", "both blocks served", exp_q.size(), 0);
      check(tc_flag == 4'b1110, "R6", "tc flags", tc_flag, 4'b1110);
      // spent channels keep requesting: no bus activity
      begin
         bit quiet = 1'b1;
         repeat (10) begin
            @(negedge clk);
            if (hrq || dack != 0) quiet = 1'b0;
         end
         check(quiet, "R6", "spent request ignored", {31'd0, quiet}, 1);
      end

      // no preemption: channel 0 arrives during channel 2 block
      @(negedge clk);
      cfg_we = 1'b1; cfg_ch = 2'd2; cfg_sel = 2'd1; cfg_wdata = 16'd5;
      @(negedge clk);
      cfg_we = 1'b0;
      check(tc_flag[2] == 1'b0, "R9", "count write clears tc", tc_flag[2], 0);
      push_block(2'd2, 16'h1004, 5, 1'b1);
      push_block(2'd0, 16'hFFFE, 2, 1'b0);
      while (dack[2] == 1'b0) @(negedge clk);
      dreq[0] = 1'b1;
      @(negedge clk);
      check(hrq && dack == 4'b0100, "R7", "block kept by channel 2", dack, 4'b0100);
      wait (irq_cnt == 5);
      @(negedge clk);
      check(exp_q.size() == 0, "R5", "address wrap block done", exp_q.size(), 0);
      check(tc_flag == 4'b1111, "R6", "all tc set", tc_flag, 4'b1111);
      check(irq_cnt == 5, "R8", "completion pulses", irq_cnt, 5);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule